// File: doc/BRIEF.md
# Shared DMA Interrupt Status Aggregator

This block gathers interrupt cause events from nine general DMA channels and one display-controller channel. It records them in per-channel 7-bit sticky status registers and drives seven level interrupt lines. Three of the lines are each shared by a pair of general channels, whose partner indices sit `NUM_CH - NUM_PAIRS` apart. The remaining general channels and the display channel each own a line.

A processor reads status through a one-cycle read port addressed by source index. General channels use indices 0 to 8 and the display channel uses index 9. A read returns a packed word one cycle later. It clears the status it returns at the same clock edge. For a paired channel, a read at either partner's index returns both channels' status in one word and clears both. An event that lands in the same cycle as a clearing read survives the clear, so no cause is lost.

Top module: `dma_irq_aggregator`

## Requirements
- R1: A cause bit pulsed on a channel's event input sets the same bit of that channel's 7-bit status at the next clock edge. The bit stays set until that channel is cleared by a read.
- R2: `irq_o[k]` for k in 0..2 is high while any status bit of channel k or channel k+6 is set. `irq_o[k]` for k in 3..5 follows channel k alone. `irq_o[6]` follows the display channel (index 9). Each line is a level that rises one cycle after the event.
- R3: Events on both channels of a pair in the same cycle raise only their one shared line, and both channels' status bits are set.
- R4: A read at index 0, 1, 2, 6, 7 or 8 returns, in `rd_data_o` one cycle after `rd_en_i`, the lower-numbered partner's status in bits [6:0] and the higher partner's status in bits [13:7], with bits [15:14] zero.
- R5: A read at index 3, 4, 5 or 9 returns that source's status in bits [6:0], with all other bits zero.
- R6: A read clears every status bit of the addressed source and, for a pair, of its partner as well. It leaves all other sources unchanged.
- R7: A cause event arriving in the same cycle as a clearing read of its channel leaves that bit set after the clear. The returned word does not include that event.
- R8: A read at index 10..15 returns zero and clears nothing.
- R9: Reset (active low, asynchronous) clears all status, all interrupt lines and `rd_data_o`.
- R10: `rd_data_o` holds its last value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chan_evt_i | input | 63 | Cause events, channel c in bits [7c+6:7c] |
| disp_evt_i | input | 7 | Cause events of the display channel |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| rd_addr_i | input | 4 | Source index being read |
| rd_data_o | output | 16 | Packed status word, registered |
| irq_o | output | 7 | Level interrupt lines |

## Verification
The bench builds the block with its default parameters: nine general channels, three pairs, 7-bit status and a 16-bit read word. These values leave the top two data bits as spare zero bits. They also put partner channels six indices apart, so every kind of source can be reached: the low and high partner addresses, the dedicated lines, the display line, and the unused indices above 9. A table-driven sequence covers reads at both addresses of each pair, events coinciding with a clear, and out-of-range reads. Directed steps then cover a full-width packed word and a reset while status is pending.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

   // What a read address refers to
   typedef enum logic [1:0] {
      SRC_PAIR = 2'd0,
      SRC_SOLO = 2'd1,
      SRC_NONE = 2'd2
   } src_kind_e;

   // Distance between the two members of a pair
   function automatic int pair_gap(input int num_ch, input int num_pairs);
      return num_ch - num_pairs;
   endfunction

   // Classify an address: general channels 0..num_ch-1, display at num_ch
   function automatic src_kind_e kind_of(input int a, input int num_ch,
                                         input int num_pairs);
      int gap;
      gap = pair_gap(num_ch, num_pairs);
      if (a < num_pairs)                return SRC_PAIR;
      if (a >= gap && a < num_ch)       return SRC_PAIR;
      if (a <= num_ch)                  return SRC_SOLO;
      return SRC_NONE;
   endfunction

   // Lower-numbered member (or the single source) for an address
   function automatic int low_of(input int a, input int num_ch,
                                 input int num_pairs);
      int gap;
      gap = pair_gap(num_ch, num_pairs);
      if (a >= gap && a < num_ch) return a - gap;
      return a;
   endfunction

   // Higher-numbered member of a pair
   function automatic int high_of(input int a, input int num_ch,
                                  input int num_pairs);
      return low_of(a, num_ch, num_pairs) + pair_gap(num_ch, num_pairs);
   endfunction

endpackage

// File: rtl/dma_irq_status_reg.sv
module dma_irq_status_reg #(
   parameter int ST_W = 7
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [ST_W-1:0] evt_i,
   input  logic            clr_i,
   output logic [ST_W-1:0] st_o
);

   logic [ST_W-1:0] st_q;
   logic [ST_W-1:0] kept;

   // A clear wipes old causes; new causes are merged after the wipe
   assign kept = clr_i ? '0 : st_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= '0;
      else         st_q <= kept | evt_i;
   end

   assign st_o = st_q;

   // R1: every pulsed cause bit is present on the next cycle
   p_evt_sets_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i != '0) |=> ((st_q & $past(evt_i)) == $past(evt_i)));

   // R1: with no event and no clear the status is sticky
   p_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && evt_i == '0) |=> $stable(st_q));

   // R6: a clear with no coincident event empties the register
   p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && evt_i == '0) |=> (st_q == '0));

   // R7: a clear with a coincident event leaves exactly that event
   p_keep_new_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (st_q == $past(evt_i)));

endmodule

// File: rtl/dma_irq_line_map.sv
module dma_irq_line_map #(
   parameter int NUM_CH    = 9,
   parameter int NUM_PAIRS = 3,
   parameter int ST_W      = 7
) (
   input  logic [(NUM_CH+1)*ST_W-1:0] st_flat_i,
   output logic [NUM_CH-NUM_PAIRS:0]  irq_o
);

   localparam int NSRC      = NUM_CH + 1;
   localparam int NUM_LINES = NUM_CH - NUM_PAIRS + 1;
   localparam int GAP       = NUM_CH - NUM_PAIRS;

   // Per-source request: all cause bits ORed
   logic [NSRC-1:0] req;

   for (genvar s = 0; s < NSRC; s++) begin : g_req
      assign req[s] = |st_flat_i[s*ST_W +: ST_W];
   end

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      if (l < NUM_PAIRS) begin : g_shared
         assign irq_o[l] = req[l] | req[l+GAP];
      end else if (l < NUM_LINES-1) begin : g_dedicated
         assign irq_o[l] = req[l];
      end else begin : g_display
         assign irq_o[l] = req[NUM_CH];
      end
   end

endmodule

// File: rtl/dma_irq_read_port.sv
module dma_irq_read_port
   import dma_irq_pkg::*;
#(
   parameter int NUM_CH    = 9,
   parameter int NUM_PAIRS = 3,
   parameter int ST_W      = 7,
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 4
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       rd_en_i,
   input  logic [ADDR_W-1:0]          rd_addr_i,
   input  logic [(NUM_CH+1)*ST_W-1:0] st_flat_i,
   output logic [NUM_CH:0]            clr_o,
   output logic [DATA_W-1:0]          rd_data_o
);

   localparam int NSRC = NUM_CH + 1;

   src_kind_e        kind;
   int               lo_idx;
   int               hi_idx;
   logic [ST_W-1:0]  lo_st;
   logic [ST_W-1:0]  hi_st;
   logic [DATA_W-1:0] word;
   logic [DATA_W-1:0] rd_q;

   // Address decode
   always_comb begin
      int a;
      a      = int'(rd_addr_i);
      kind   = kind_of(a, NUM_CH, NUM_PAIRS);
      lo_idx = low_of(a, NUM_CH, NUM_PAIRS);
      hi_idx = high_of(a, NUM_CH, NUM_PAIRS);
   end

   // Select the addressed status fields without variable indexing
   always_comb begin
      lo_st = '0;
      hi_st = '0;
      for (int s = 0; s < NSRC; s++) begin
         if (lo_idx == s) lo_st = st_flat_i[s*ST_W +: ST_W];
         if (hi_idx == s) hi_st = st_flat_i[s*ST_W +: ST_W];
      end
   end

   // Pack the returned word
   always_comb begin
      word = '0;
      case (kind)
         SRC_PAIR: begin
            word[ST_W-1:0]      = lo_st;
            word[2*ST_W-1:ST_W] = hi_st;
         end
         SRC_SOLO: word[ST_W-1:0] = lo_st;
         default:  word = '0;
      endcase
   end

   // Clear strobes: the addressed source and, for a pair, its partner
   always_comb begin
      for (int s = 0; s < NSRC; s++) begin
         clr_o[s] = rd_en_i &&
                    ((kind != SRC_NONE && lo_idx == s) ||
                     (kind == SRC_PAIR && hi_idx == s));
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      rd_q <= '0;
      else if (rd_en_i) rd_q <= word;
   end

   assign rd_data_o = rd_q;

   // R8: addresses past the display index read as zero
   p_oob_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && int'(rd_addr_i) > NUM_CH) |=> (rd_data_o == '0));

   // R8: addresses past the display index clear nothing
   p_oob_noclr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(rd_addr_i) > NUM_CH) |-> (clr_o == '0));

   // R10: read data is held between reads
   p_rd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_en_i |=> $stable(rd_data_o));

endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator #(
   parameter int NUM_CH    = 9,
   parameter int NUM_PAIRS = 3,
   parameter int ST_W      = 7,
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 4
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic [NUM_CH*ST_W-1:0]   chan_evt_i,
   input  logic [ST_W-1:0]          disp_evt_i,
   input  logic                     rd_en_i,
   input  logic [ADDR_W-1:0]        rd_addr_i,
   output logic [DATA_W-1:0]        rd_data_o,
   output logic [NUM_CH-NUM_PAIRS:0] irq_o
);

   localparam int NSRC      = NUM_CH + 1;
   localparam int NUM_LINES = NUM_CH - NUM_PAIRS + 1;
   localparam int GAP       = NUM_CH - NUM_PAIRS;

   // Elaboration-time parameter checks
   if (DATA_W < 2*ST_W) begin : g_bad_data_w
      $error("read word too narrow for a packed pair");
   end
   if ((2**ADDR_W) < NSRC) begin : g_bad_addr_w
      $error("address too narrow for all sources");
   end
   if (2*NUM_PAIRS > NUM_CH) begin : g_bad_pairs
      $error("more pairs than channels allow");
   end

   logic [NSRC*ST_W-1:0] evt_all;
   logic [NSRC*ST_W-1:0] st_flat;
   logic [NSRC-1:0]      clr;

   assign evt_all = {disp_evt_i, chan_evt_i};

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      dma_irq_status_reg #(.ST_W(ST_W)) u_st (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .evt_i  (evt_all[s*ST_W +: ST_W]),
         .clr_i  (clr[s]),
         .st_o   (st_flat[s*ST_W +: ST_W])
      );
   end

   dma_irq_line_map #(
      .NUM_CH    (NUM_CH),
      .NUM_PAIRS (NUM_PAIRS),
      .ST_W      (ST_W)
   ) u_map (
      .st_flat_i (st_flat),
      .irq_o     (irq_o)
   );

   dma_irq_read_port #(
      .NUM_CH    (NUM_CH),
      .NUM_PAIRS (NUM_PAIRS),
      .ST_W      (ST_W),
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W)
   ) u_rd (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rd_en_i   (rd_en_i),
      .rd_addr_i (rd_addr_i),
      .st_flat_i (st_flat),
      .clr_o     (clr),
      .rd_data_o (rd_data_o)
   );

   // R2: an event on a general channel raises its line next cycle
   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk_line
      localparam int LN = (c < GAP) ? c : c - GAP;
      p_evt_raises_line_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (chan_evt_i[c*ST_W +: ST_W] != '0) |=> irq_o[LN]);
   end

   // R2: the display channel drives the last line
   p_disp_line_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (disp_evt_i != '0) |=> irq_o[NUM_LINES-1]);

   // R6: reading the high partner with no events drops the shared line
   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_chk_pair
      p_pair_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (rd_en_i && int'(rd_addr_i) == p + GAP && evt_all == '0) |=> !irq_o[p]);
   end

endmodule

// File: tb/dma_irq_aggregator_tb_top.sv
module dma_irq_aggregator_tb_top;

   logic        clk;
   logic        rst_n;
   logic [62:0] chan_evt;
   logic [6:0]  disp_evt;
   logic        rd_en;
   logic [3:0]  rd_addr;
   logic [15:0] rd_data;
   logic [6:0]  irq;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   dma_irq_aggregator dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .chan_evt_i (chan_evt),
      .disp_evt_i (disp_evt),
      .rd_en_i    (rd_en),
      .rd_addr_i  (rd_addr),
      .rd_data_o  (rd_data),
      .irq_o      (irq)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   // One step: event channel a/b (15 = none, 9 = display), optional read
   typedef struct packed {
      logic [3:0]  ca;
      logic [6:0]  ea;
      logic [3:0]  cb;
      logic [6:0]  eb;
      logic        rd;
      logic [3:0]  addr;
      logic [6:0]  x_irq;
      logic [15:0] x_data;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{4'd0, 7'h01, 4'd15, 7'h00, 1'b0, 4'd0,  7'h01, 16'h0000}, // R1 R2
      '{4'd1, 7'h03, 4'd7,  7'h40, 1'b0, 4'd0,  7'h03, 16'h0000}, // R3
      '{4'd15,7'h00, 4'd15, 7'h00, 1'b1, 4'd7,  7'h01, 16'h2003}, // R4 R6
      '{4'd4, 7'h55, 4'd15, 7'h00, 1'b1, 4'd6,  7'h10, 16'h0001}, // R4 R6
      '{4'd9, 7'h7F, 4'd15, 7'h00, 1'b1, 4'd4,  7'h40, 16'h0055}, // R5 R2
      '{4'd15,7'h00, 4'd15, 7'h00, 1'b1, 4'd12, 7'h40, 16'h0000}, // R8
      '{4'd2, 7'h08, 4'd8,  7'h04, 1'b1, 4'd9,  7'h04, 16'h007F}, // R5 R3
      '{4'd8, 7'h01, 4'd15, 7'h00, 1'b1, 4'd2,  7'h04, 16'h0208}, // R7
      '{4'd15,7'h00, 4'd15, 7'h00, 1'b1, 4'd8,  7'h00, 16'h0080}, // R7 R4
      '{4'd3, 7'h20, 4'd5,  7'h02, 1'b0, 4'd0,  7'h28, 16'h0080}, // R2 R10
      '{4'd15,7'h00, 4'd15, 7'h00, 1'b1, 4'd3,  7'h20, 16'h0020}, // R5 R6
      '{4'd5, 7'h02, 4'd15, 7'h00, 1'b1, 4'd5,  7'h20, 16'h0002}, // R7
      '{4'd15,7'h00, 4'd15, 7'h00, 1'b1, 4'd5,  7'h00, 16'h0002}, // R7
      '{4'd15,7'h00, 4'd15, 7'h00, 1'b1, 4'd0,  7'h00, 16'h0000}  // R6
   };

   task automatic check(input string req, input logic [15:0] act,
                        input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put_evt(input logic [3:0] ch, input logic [6:0] b);
      if (ch < 4'd9)       chan_evt[ch*7 +: 7] = b;
      else if (ch == 4'd9) disp_evt = b;
   endtask

   task automatic step(input logic [3:0] ca, input logic [6:0] ea,
                       input logic [3:0] cb, input logic [6:0] eb,
                       input logic r, input logic [3:0] a);
      @(negedge clk);
      chan_evt = '0;
      disp_evt = '0;
      put_evt(ca, ea);
      put_evt(cb, eb);
      rd_en   = r;
      rd_addr = a;
      @(posedge clk);
      #1;
      @(negedge clk);
      chan_evt = '0;
      disp_evt = '0;
      rd_en    = 1'b0;
   endtask

   initial begin
      int wd = 0;
      while (!done && wd < 20000) begin
         @(posedge clk);
         wd++;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=<20000", wd);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n    = 1'b0;
      chan_evt = '0;
      disp_evt = '0;
      rd_en    = 1'b0;
      rd_addr  = '0;
      repeat (3) @(posedge clk);
      #1;
      // R9: reset state
      check("R9 irq at reset", {9'd0, irq}, 16'h0000);
      check("R9 rd_data at reset", rd_data, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;

      // Table walk: sampled just after the edge that applies each step
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         chan_evt = '0;
         disp_evt = '0;
         put_evt(VECS[i].ca, VECS[i].ea);
         put_evt(VECS[i].cb, VECS[i].eb);
         rd_en   = VECS[i].rd;
         rd_addr = VECS[i].addr;
         @(posedge clk);
         #1;
         check($sformatf("R2 irq vec %0d", i), {9'd0, irq}, {9'd0, VECS[i].x_irq});
         check($sformatf("R4 R5 rd_data vec %0d", i), rd_data, VECS[i].x_data);
      end
      @(negedge clk);
      chan_evt = '0;
      disp_evt = '0;
      rd_en    = 1'b0;

      // R4: full-width high partner, spare top bits read zero
      step(4'd6, 7'h7F, 4'd15, 7'h00, 1'b0, 4'd0);
      check("R2 irq after ch6 event", {9'd0, irq}, 16'h0001);
      step(4'd15, 7'h00, 4'd15, 7'h00, 1'b1, 4'd0);
      check("R4 packed high partner", rd_data, 16'h3F80);
      check("R6 line cleared after pair read", {9'd0, irq}, 16'h0000);

      // R9: reset with status pending
      step(4'd3, 7'h11, 4'd15, 7'h00, 1'b0, 4'd0);
      check("R1 ch3 pending", {9'd0, irq}, 16'h0008);
      rst_n = 1'b0;
      #1;
      check("R9 irq during reset", {9'd0, irq}, 16'h0000);
      check("R9 rd_data during reset", rd_data, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;
      step(4'd15, 7'h00, 4'd15, 7'h00, 1'b1, 4'd3);
      check("R9 status empty after reset", rd_data, 16'h0000);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule